// File: doc/BRIEF.md
# DTMF Receive Steering Validator

This block is the digital steering and guard-time stage of a tone-pair receiver. It sits behind a frequency decoder. That decoder supplies an early-steering level, high while a valid tone pair is present, and the 4-bit code of that pair. The validator decides whether the tone lasted long enough to count as a digit. It also decides whether a later gap lasted long enough to count as a real pause between digits.

Two programmable guard times, counted in clock cycles, control these decisions. A burst shorter than the tone-present guard time is thrown away. A drop-out shorter than the tone-absent guard time is bridged, so the current digit stays registered. When a tone is accepted, its code is captured into the receive data output and the guard-time output goes active. After a fixed settling delay, the delayed-steering flag rises together with a one-cycle receive-full pulse. The flag falls only after a validated pause, and the captured code is kept until the next tone is accepted.

Top module: `dtmf_steer_validator`

## Requirements
- R1: During and right after reset, rx_data_o is 0 and dstd_o, rx_full_o and guard_o are all 0.
- R2: Let N be present_time_i, with a value of 0 treated as 1. With dstd_o low and no tone pending, a tone is registered on the N-th consecutive clock edge at which est_i is sampled high. On that edge rx_data_o takes the value of digit_i sampled at that edge.
- R3: A burst of est_i high that ends before N consecutive high edges leaves rx_data_o, dstd_o and guard_o unchanged. It also restarts the count.
- R4: guard_o goes high on the registration edge. While the tone stays registered, guard_o equals est_i as sampled at the previous edge. It returns to 0 on the edge that validates the pause, and it stays 0 while no tone is registered.
- R5: dstd_o rises exactly 2 clock edges after the registration edge, whatever est_i does in between.
- R6: rx_full_o is high for exactly one cycle: the cycle in which dstd_o has just risen. It is low at all other times.
- R7: Let M be absent_time_i, with a value of 0 treated as 1. Once dstd_o is high, a run of fewer than M consecutive low samples of est_i leaves dstd_o and rx_data_o unchanged, and the absence count restarts.
- R8: dstd_o falls on the M-th consecutive edge at which est_i is sampled low after dstd_o rose. rx_data_o keeps its value.
- R9: rx_data_o changes only on a registration edge. At every other edge digit_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| est_i | input | 1 | Early steering: valid tone pair present |
| digit_i | input | 4 | Decoded tone-pair code |
| present_time_i | input | 16 | Tone-present guard time in cycles (0 acts as 1) |
| absent_time_i | input | 16 | Tone-absent guard time in cycles (0 acts as 1) |
| rx_data_o | output | 4 | Receive data register |
| dstd_o | output | 1 | Delayed steering flag |
| rx_full_o | output | 1 | One-cycle pulse when a new digit is registered |
| guard_o | output | 1 | Guard-time status |

## Verification
Two events can share a cycle in this block. The first case is a drop-out of est_i that lands inside the two-cycle settling window: the settle countdown and guard_o's tracking of est_i then happen in the same cycles, and dstd_o must still rise on time. The second case is a new tone that starts on the edge right after a pause has been validated: the fall of dstd_o and the first tone-present count happen back to back. Random runs of est_i with lengths close to both guard times produce these cases many times, and directed drop-outs aimed at the settling window produce them on purpose. In both cases, every output is compared on every cycle against a cycle model written from the requirements.

// File: rtl/dsv_pkg.sv
package dsv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_HELD   = 2'd2
  } steer_state_e;
endpackage

// File: rtl/guard_timer.sv
// Counts consecutive cycles with run_i high; hit_o on the limit-th one.
module guard_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] limit_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   next_w;
  logic [CW:0]   lim_eff;

  assign next_w  = {1'b0, cnt_q} + 1'b1;
  assign lim_eff = (limit_i == '0) ? {{CW{1'b0}}, 1'b1} : {1'b0, limit_i};
  assign hit_o   = run_i && (next_w >= lim_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (hit_o)  cnt_q <= '0;
    else             cnt_q <= next_w[CW-1:0];
  end

  // R2
  cnt_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_i) |-> (cnt_q == '0));
endmodule

// File: rtl/settle_delay.sv
// Fixed-length shift chain: done_o high during the N-th cycle after start_i.
module settle_delay #(
  parameter int unsigned N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  logic [N-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q[0] <= 1'b0;
    else         sr_q[0] <= start_i;
  end

  for (genvar i = 1; i < N; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q[i] <= 1'b0;
      else         sr_q[i] <= sr_q[i-1];
    end
  end

  assign done_o = sr_q[N-1];

  // R5
  settle_one_hot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sr_q));
endmodule

// File: rtl/dtmf_steer_validator.sv
module dtmf_steer_validator #(
  parameter int unsigned TW         = 16,
  parameter int unsigned DW         = 4,
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          est_i,
  input  logic [DW-1:0] digit_i,
  input  logic [TW-1:0] present_time_i,
  input  logic [TW-1:0] absent_time_i,
  output logic [DW-1:0] rx_data_o,
  output logic          dstd_o,
  output logic          rx_full_o,
  output logic          guard_o
);
  import dsv_pkg::*;

  steer_state_e  state_q;
  logic [DW-1:0] data_q;
  logic          dstd_q, full_q, guard_q;
  logic          p_run, a_run, p_hit, a_hit, settle_done;

  assign p_run = (state_q == ST_IDLE) && est_i;
  assign a_run = (state_q == ST_HELD) && !est_i;

  guard_timer #(.CW(TW)) u_present (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (p_run),
    .limit_i(present_time_i),
    .hit_o  (p_hit)
  );

  guard_timer #(.CW(TW)) u_absent (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (a_run),
    .limit_i(absent_time_i),
    .hit_o  (a_hit)
  );

  settle_delay #(.N(SETTLE_CYC)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(p_hit),
    .done_o (settle_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      dstd_q  <= 1'b0;
      full_q  <= 1'b0;
      guard_q <= 1'b0;
    end else begin
      full_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (p_hit) begin
            state_q <= ST_SETTLE;
            data_q  <= digit_i;
            guard_q <= 1'b1;
          end
        end
        ST_SETTLE: begin
          guard_q <= est_i;
          if (settle_done) begin
            state_q <= ST_HELD;
            dstd_q  <= 1'b1;
            full_q  <= 1'b1;
          end
        end
        ST_HELD: begin
          guard_q <= est_i;
          if (a_hit) begin
            state_q <= ST_IDLE;
            dstd_q  <= 1'b0;
            guard_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rx_data_o = data_q;
  assign dstd_o    = dstd_q;
  assign rx_full_o = full_q;
  assign guard_o   = guard_q;

  // R5
  dstd_after_settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dstd_o) |-> $past(state_q == ST_SETTLE));
  // R6
  full_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_o |-> $rose(dstd_o));
  // R6
  rise_gives_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dstd_o) |-> rx_full_o);
  // R9
  data_only_on_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_data_o) |-> $past(p_hit));
  // R8
  dstd_fall_on_absence_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dstd_o) |-> ($past(!est_i) && $stable(rx_data_o)));
  // R4
  guard_tracks_est_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HELD && $past(state_q == ST_HELD)) |-> (guard_o == $past(est_i)));
  // R4
  guard_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !guard_o);
endmodule

// File: tb/dtmf_steer_validator_tb.sv
module dtmf_steer_validator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        est = 1'b0;
  logic [3:0]  digit = 4'd0;
  logic [15:0] tp = 16'd5, ta = 16'd4;
  logic [3:0]  rx_data;
  logic        dstd, rx_full, guard;

  int n_tests = 0, n_fail = 0;

  // reference model state
  int          m_mode = 0;  // 0 idle, 1 settle, 2 held
  int          m_pcnt = 0, m_acnt = 0, m_scnt = 0;
  logic [3:0]  m_data = 0;
  logic        m_dstd = 0, m_full = 0, m_guard = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtmf_steer_validator u_dut (
    .clk_i(clk), .rst_ni(rst_n), .est_i(est), .digit_i(digit),
    .present_time_i(tp), .absent_time_i(ta),
    .rx_data_o(rx_data), .dstd_o(dstd), .rx_full_o(rx_full), .guard_o(guard)
  );

  function automatic int eff(input logic [15:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge(input logic e, input logic [3:0] d);
    m_full = 0;
    case (m_mode)
      0: begin
        if (e) begin
          if (m_pcnt + 1 >= eff(tp)) begin
            m_data = d; m_guard = 1; m_mode = 1; m_scnt = 0; m_pcnt = 0;
          end else m_pcnt++;
        end else m_pcnt = 0;
      end
      1: begin
        m_guard = e;
        if (m_scnt + 1 >= SETTLE) begin
          m_dstd = 1; m_full = 1; m_mode = 2; m_acnt = 0;
        end else m_scnt++;
      end
      default: begin
        m_guard = e;
        if (!e) begin
          if (m_acnt + 1 >= eff(ta)) begin
            m_mode = 0; m_dstd = 0; m_guard = 0; m_acnt = 0;
          end else m_acnt++;
        end else m_acnt = 0;
      end
    endcase
  endtask

  task automatic compare_all();
    chk("R2/R9 rx_data", rx_data, m_data);
    chk("R5/R8 dstd", dstd, m_dstd);
    chk("R6 rx_full", rx_full, m_full);
    chk("R4 guard", guard, m_guard);
  endtask

  // called at a negedge; drives, advances model, checks at next negedge
  task automatic step(input logic e, input logic [3:0] d);
    est = e; digit = d;
    model_edge(e, d);
    @(negedge clk);
    compare_all();
  endtask

  task automatic run(input logic e, input int n, input logic [3:0] d);
    for (int i = 0; i < n; i++) step(e, d);
  endtask

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rx_data", rx_data, 0);
    chk("R1 dstd", dstd, 0);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 guard", guard, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release dstd", dstd, 0);

    // directed, tp=5 ta=4
    run(1'b1, 4, 4'd9);
    run(1'b0, 3, 4'd9);
    chk("R3 short burst data", rx_data, 0);
    chk("R3 short burst guard", guard, 0);
    chk("R3 short burst dstd", dstd, 0);
    run(1'b1, 5, 4'd7);
    chk("R2 latched digit", rx_data, 7);
    chk("R5 no flag yet", dstd, 0);
    step(1'b0, 4'd3);  // drop-out inside settle window
    step(1'b1, 4'd3);
    chk("R5 flag at +2", dstd, 1);
    chk("R6 pulse", rx_full, 1);
    step(1'b1, 4'd3);
    chk("R6 pulse ends", rx_full, 0);
    run(1'b0, 3, 4'd1);
    step(1'b1, 4'd1);
    chk("R7 dropout dstd", dstd, 1);
    chk("R7 dropout data", rx_data, 7);
    run(1'b0, 4, 4'd2);
    chk("R8 flag cleared", dstd, 0);
    chk("R8 data kept", rx_data, 7);
    // new tone right after validated pause
    run(1'b1, 5, 4'd12);
    chk("R9 new digit", rx_data, 12);
    run(1'b1, 3, 4'd5);
    chk("R9 digit ignored while held", rx_data, 12);
    run(1'b0, 6, 4'd0);

    // zero limits act as one
    tp = 16'd0; ta = 16'd0;
    step(1'b1, 4'd4);
    chk("R2 zero limit latch", rx_data, 4);
    run(1'b1, 2, 4'd4);
    chk("R5 zero limit flag", dstd, 1);
    step(1'b0, 4'd4);
    chk("R8 zero limit clear", dstd, 0);
    run(1'b0, 3, 4'd0);

    // constrained random
    for (int seg = 0; seg < 30; seg++) begin
      tp = 16'($urandom_range(1, 10));
      ta = 16'($urandom_range(1, 10));
      for (int r = 0; r < 40; r++) begin
        int len;
        len = $urandom_range(1, 13);
        for (int k = 0; k < len; k++) step(r[0] ? 1'b0 : 1'b1, 4'($urandom));
      end
      run(1'b0, 16, 4'd0);  // settle to idle before changing limits
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule